// File: doc/BRIEF.md
# CEC Frame Receiver with Destination Filter

This block sits behind a CEC bit classifier. Each cycle it may receive one classified symbol, which is either a start marker or a data bit with its value. It may also receive an overflow strobe, which the classifier raises when the line stays idle too long. From this stream the block builds ten-bit blocks: eight data bits sent most significant bit first, then an end-of-message bit, then an acknowledge bit.

The first block after a start marker is the header. Its low nibble carries the destination address, and this can be compared with a programmed device address. On a mismatch the block stores nothing and raises no flag, and it drops back to waiting for the next start marker. The host can therefore sleep through traffic meant for other devices.

Each accepted block is written to a byte register. On the way in, the bits can optionally be mirrored. The end-of-message and acknowledge bits are latched beside the byte. Three sticky flags (start seen, block received, overflow) each have an enable, and the enabled flags together drive one interrupt line. The block only receives: it never drives the bus or sends acknowledges.

Top module: `cec_frame_rx`

## Requirements
- R1: After reset the flags `stStart`, `stBlock` and `stOvf` are 0, and so are `rxData`, `rxEom`, `rxAck` and `irq`.
- R2: A symbol with `symValid=1` and `symStart=1` sets `stStart` on the next clock edge. The receiver then expects a header block. This holds in every state while `enable=1`.
- R3: After a start, data symbols (`symValid=1`, `symStart=0`) are taken in this order: 8 data bits with the most significant bit first, then the end-of-message bit, then the acknowledge bit. On the edge that takes the acknowledge bit, an accepted block loads `rxData`, `rxEom` and `rxAck` (the acknowledge symbol's value) and sets `stBlock`.
- R4: When `addrCmpEn=1`, header bits 3:0 (the destination) are compared with `devAddr`, and header bits 7:4 are the source. On a mismatch nothing is stored and `stBlock` stays 0. All later blocks are then ignored until the next start.
- R5: When `addrCmpEn=0`, every header is accepted whatever its destination.
- R6: When `swapBits=1`, `rxData` bit i receives received data bit 7-i. When `swapBits=0`, the byte is stored as received.
- R7: After an accepted block with end-of-message 1, the receiver waits for a start. Data symbols that arrive before the next start change nothing.
- R8: A start inside a block discards the partial block and restarts reception. The next block is treated as a header.
- R9: `ovfStrobe` during a message sets `stOvf` and aborts the message. While the receiver is waiting for a start, `ovfStrobe` is ignored.
- R10: Each flag stays set until its clear input (`clrStart`, `clrBlock`, `clrOvf`) is pulsed high. If a flag is set and cleared in the same cycle, the set wins.
- R11: `irq` is 1 exactly when at least one flag is set together with its enable (`ieStart`, `ieBlock`, `ieOvf`).
- R12: While `enable=0`, symbols and overflow strobes are ignored and the receiver returns to waiting for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable |
| addrCmpEn | input | 1 | Destination compare enable |
| devAddr | input | 4 | Programmed device address |
| swapBits | input | 1 | Mirror the byte before storing |
| symValid | input | 1 | Symbol present this cycle |
| symStart | input | 1 | Symbol is a start marker |
| symBit | input | 1 | Data bit value |
| ovfStrobe | input | 1 | Line-timeout strobe from classifier |
| ieStart | input | 1 | Start flag interrupt enable |
| ieBlock | input | 1 | Block flag interrupt enable |
| ieOvf | input | 1 | Overflow flag interrupt enable |
| clrStart | input | 1 | Clear pulse for start flag |
| clrBlock | input | 1 | Clear pulse for block flag |
| clrOvf | input | 1 | Clear pulse for overflow flag |
| rxData | output | 8 | Last accepted byte |
| rxEom | output | 1 | End-of-message bit of last accepted block |
| rxAck | output | 1 | Acknowledge bit of last accepted block |
| stStart | output | 1 | Start seen flag |
| stBlock | output | 1 | Block received flag |
| stOvf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several things on every cycle. The byte register changes only on a load strobe, and a load happens only at the acknowledge position of the bit counter. Overflow is recorded only inside a message, disabling forces the idle state, flags rise only from their set strobes, and an interrupt never appears without a flag. Other behaviour can only be shown by the bench's scenarios, because it depends on whole symbol sequences: the bit order, the header compare and the silence that follows a mismatch, mirroring, the return to idle after end-of-message, and the abort on a mid-block start.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic {RX_IDLE = 1'b0, RX_BLOCK = 1'b1} rxState_e;

  typedef struct packed {
    logic shiftEn;
    logic clearShift;
    logic loadData;
    logic setStart;
    logic setBlock;
    logic setOvf;
  } rxStrobe_t;
endpackage

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
  import cec_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              addrCmpEn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              symValid,
  input  logic              symStart,
  input  logic              ovfStrobe,
  input  logic [ADDR_W-1:0] destField,
  input  logic              eomBit,
  output rxStrobe_t         strb
);
  localparam int LAST = DATA_W + 1;
  localparam int CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LAST);

  rxState_e state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic isHeader, nextHdr;
  logic gotBit, destMiss;

  assign gotBit   = symValid && !symStart;
  assign destMiss = isHeader && addrCmpEn && (destField != devAddr);

  always_comb begin
    strb      = '0;
    nextState = state;
    nextCnt   = bitCnt;
    nextHdr   = isHeader;
    if (!enable) begin
      nextState = RX_IDLE;
      nextCnt   = '0;
    end else if (symValid && symStart) begin
      strb.setStart   = 1'b1;
      strb.clearShift = 1'b1;
      nextState       = RX_BLOCK;
      nextCnt         = '0;
      nextHdr         = 1'b1;
    end else if (state == RX_BLOCK && ovfStrobe) begin
      strb.setOvf = 1'b1;
      nextState   = RX_IDLE;
      nextCnt     = '0;
    end else if (state == RX_BLOCK && gotBit) begin
      if (bitCnt == LAST_CNT) begin
        nextCnt = '0;
        if (destMiss) begin
          nextState = RX_IDLE;
        end else begin
          strb.loadData   = 1'b1;
          strb.setBlock   = 1'b1;
          strb.clearShift = 1'b1;
          nextHdr         = 1'b0;
          if (eomBit) nextState = RX_IDLE;
        end
      end else begin
        strb.shiftEn = 1'b1;
        nextCnt      = bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      bitCnt   <= '0;
      isHeader <= 1'b0;
    end else begin
      state    <= nextState;
      bitCnt   <= nextCnt;
      isHeader <= nextHdr;
    end
  end

  a_r12_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> state == RX_IDLE);
  a_r3_load_at_ack: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |-> (state == RX_BLOCK && bitCnt == LAST_CNT));
  a_r9_ovf_in_msg: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOvf |-> state == RX_BLOCK);
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_CNT);
  a_r7_idle_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE) |-> !strb.loadData);
endmodule

// File: rtl/cec_rx_datapath.sv
module cec_rx_datapath
  import cec_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              symBit,
  input  logic              swapBits,
  input  logic              ieStart,
  input  logic              ieBlock,
  input  logic              ieOvf,
  input  logic              clrStart,
  input  logic              clrBlock,
  input  logic              clrOvf,
  output logic [ADDR_W-1:0] destField,
  output logic              eomBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxEom,
  output logic              rxAck,
  output logic              stStart,
  output logic              stBlock,
  output logic              stOvf,
  output logic              irq
);
  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0]   shiftReg;
  logic [DATA_W-1:0] rawByte, mirrored, storeByte;

  assign rawByte   = shiftReg[SH_W-1:1];
  assign eomBit    = shiftReg[0];
  assign destField = rawByte[ADDR_W-1:0];

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mirror
    assign mirrored[gi] = rawByte[DATA_W-1-gi];
  end
  assign storeByte = swapBits ? mirrored : rawByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.clearShift) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[SH_W-2:0], symBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxEom  <= 1'b0;
      rxAck  <= 1'b0;
    end else if (strb.loadData) begin
      rxData <= storeByte;
      rxEom  <= eomBit;
      rxAck  <= symBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stStart <= 1'b0;
      stBlock <= 1'b0;
      stOvf   <= 1'b0;
    end else begin
      stStart <= strb.setStart | (stStart & ~clrStart);
      stBlock <= strb.setBlock | (stBlock & ~clrBlock);
      stOvf   <= strb.setOvf   | (stOvf   & ~clrOvf);
    end
  end

  assign irq = (stStart & ieStart) | (stBlock & ieBlock) | (stOvf & ieOvf);

  a_r3_data_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> $past(strb.loadData));
  a_r10_block_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stBlock) |-> $past(strb.setBlock));
  a_r10_ovf_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stOvf) && !$past(clrOvf)) |-> stOvf);
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (stStart || stBlock || stOvf));
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
  import cec_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              addrCmpEn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              swapBits,
  input  logic              symValid,
  input  logic              symStart,
  input  logic              symBit,
  input  logic              ovfStrobe,
  input  logic              ieStart,
  input  logic              ieBlock,
  input  logic              ieOvf,
  input  logic              clrStart,
  input  logic              clrBlock,
  input  logic              clrOvf,
  output logic [DATA_W-1:0] rxData,
  output logic              rxEom,
  output logic              rxAck,
  output logic              stStart,
  output logic              stBlock,
  output logic              stOvf,
  output logic              irq
);
  rxStrobe_t         strb;
  logic [ADDR_W-1:0] destField;
  logic              eomBit;

  cec_rx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .addrCmpEn(addrCmpEn),
    .devAddr(devAddr), .symValid(symValid), .symStart(symStart),
    .ovfStrobe(ovfStrobe), .destField(destField), .eomBit(eomBit),
    .strb(strb)
  );

  cec_rx_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .symBit(symBit),
    .swapBits(swapBits), .ieStart(ieStart), .ieBlock(ieBlock),
    .ieOvf(ieOvf), .clrStart(clrStart), .clrBlock(clrBlock),
    .clrOvf(clrOvf), .destField(destField), .eomBit(eomBit),
    .rxData(rxData), .rxEom(rxEom), .rxAck(rxAck), .stStart(stStart),
    .stBlock(stBlock), .stOvf(stOvf), .irq(irq)
  );
endmodule

// File: tb/tb_cec_frame_rx.sv
module tb_cec_frame_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, addrCmpEn = 1'b0, swapBits = 1'b0;
  logic [3:0] devAddr = 4'h0;
  logic symValid = 1'b0, symStart = 1'b0, symBit = 1'b0, ovfStrobe = 1'b0;
  logic ieStart = 1'b0, ieBlock = 1'b0, ieOvf = 1'b0;
  logic clrStart = 1'b0, clrBlock = 1'b0, clrOvf = 1'b0;
  logic [7:0] rxData;
  logic rxEom, rxAck, stStart, stBlock, stOvf, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cec_frame_rx dut (.*);

  function automatic logic [7:0] expByte(logic [7:0] b, logic sw);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return sw ? r : b;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic sendStart();
    @(negedge clk); symValid = 1; symStart = 1; symBit = 0;
    @(negedge clk); symValid = 0; symStart = 0;
  endtask

  task automatic sendBit(logic b);
    @(negedge clk); symValid = 1; symStart = 0; symBit = b;
    @(negedge clk); symValid = 0;
  endtask

  task automatic sendBlock(logic [7:0] b, logic eom, logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sendBit(eom);
    sendBit(ack);
  endtask

  task automatic clearAll();
    @(negedge clk); clrStart = 1; clrBlock = 1; clrOvf = 1;
    @(negedge clk); clrStart = 0; clrBlock = 0; clrOvf = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flags", {29'd0, stStart, stBlock, stOvf}, 0);
    check("R1 data", {22'd0, rxData, rxEom, rxAck}, 0);
    check("R1 irq", irq, 0);
    rstN = 1; enable = 1; devAddr = 4'h4; addrCmpEn = 1;
    @(negedge clk);

    // R2, R3, R4 match: header 0x04 then data 0xA5 eom
    sendStart();
    check("R2 start flag", stStart, 1);
    sendBlock(8'h04, 0, 1);
    check("R3 header stored", rxData, 8'h04);
    check("R3 block flag", stBlock, 1);
    check("R3 ack", rxAck, 1);
    clearAll();
    check("R10 cleared", {stStart, stBlock}, 0);
    sendBlock(8'hA5, 1, 0);
    check("R3 msb first", rxData, 8'hA5);
    check("R3 eom", rxEom, 1);
    clearAll();
    // R7 bits after eom ignored
    sendBlock(8'h3C, 0, 0);
    check("R7 no block after eom", stBlock, 0);
    check("R7 data kept", rxData, 8'hA5);

    // R4 mismatch: later blocks ignored
    sendStart(); clearAll();
    sendBlock(8'h45, 0, 0);
    check("R4 mismatch no flag", stBlock, 0);
    sendBlock(8'h77, 1, 0);
    check("R4 following ignored", stBlock, 0);
    check("R4 data kept", rxData, 8'hA5);

    // R5 compare off
    addrCmpEn = 0;
    sendStart(); sendBlock(8'h4E, 1, 0);
    check("R5 any dest", {stBlock, rxData}, {1'b1, 8'h4E});
    clearAll(); addrCmpEn = 1;

    // R6 swap
    swapBits = 1;
    sendStart(); sendBlock(8'h14, 1, 0);
    check("R6 mirrored", rxData, 8'h28);
    swapBits = 0; clearAll();

    // R8 start mid-block, then mismatching header must be filtered
    sendStart(); sendBlock(8'h04, 0, 0); clearAll();
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    sendStart(); sendBlock(8'h01, 0, 0);
    check("R8 restart as header", stBlock, 0);
    sendStart(); for (int i = 0; i < 4; i++) sendBit(1'b0);
    sendStart(); sendBlock(8'hF4, 1, 1);
    check("R8 realigned", {stBlock, rxData}, {1'b1, 8'hF4});
    clearAll();

    // R9 overflow
    @(negedge clk); ovfStrobe = 1; @(negedge clk); ovfStrobe = 0;
    check("R9 idle ovf ignored", stOvf, 0);
    sendStart(); sendBit(1);
    @(negedge clk); ovfStrobe = 1; @(negedge clk); ovfStrobe = 0;
    check("R9 ovf set", stOvf, 1);
    for (int i = 0; i < 9; i++) sendBit(1'b0);
    check("R9 aborted", stBlock, 0);

    // R11 irq
    ieOvf = 1; @(negedge clk);
    check("R11 irq on", irq, 1);
    ieOvf = 0; @(negedge clk);
    check("R11 irq masked", irq, 0);
    clearAll();
    check("R10 ovf cleared", stOvf, 0);

    // R10 set wins over clear
    @(negedge clk); symValid = 1; symStart = 1; clrStart = 1;
    @(negedge clk); symValid = 0; symStart = 0; clrStart = 0;
    check("R10 set wins", stStart, 1);
    clearAll();

    // R12 disabled
    enable = 0;
    sendStart(); sendBlock(8'h04, 1, 0);
    check("R12 ignored", {stStart, stBlock}, 0);
    enable = 1;

    // random messages
    for (int m = 0; m < 40; m++) begin
      logic [3:0] dst;
      logic acc;
      int n;
      devAddr = 4'($urandom);
      addrCmpEn = 1'($urandom);
      swapBits = 1'($urandom);
      ieBlock = 1'($urandom);
      dst = ($urandom % 2) ? devAddr : 4'($urandom);
      acc = !addrCmpEn || (dst == devAddr);
      n = $urandom % 4;
      sendStart(); clearAll();
      for (int b = 0; b <= n; b++) begin
        logic [7:0] by;
        logic ak;
        by = (b == 0) ? {4'($urandom), dst} : 8'($urandom);
        ak = 1'($urandom);
        sendBlock(by, (b == n), ak);
        check("R4 random accept", stBlock, acc);
        check("R11 random irq", irq, acc & ieBlock);
        if (acc) begin
          check("R6 random data", rxData, expByte(by, swapBits));
          check("R3 random eom/ack", {rxEom, rxAck}, {(b == n), ak});
        end
        clearAll();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule